// File: doc/BRIEF.md
# Serial Link Mode and Bit-Rate Probe

This block sits on a serial receive line straight after reset and measures the first byte a host sends. Normal reception stays off while this runs. A free-running, saturating tick counter timestamps four edges of that byte, in this order:

- the first falling edge (A);
- the rising edge after it (B);
- the falling edge after that (C);
- the rising edge after that (D).

From those timestamps the block decides whether the host wants asynchronous UART framing or clocked synchronous transfers. It also produces a bit-period figure that later receive and transmit logic can use as a divisor.

The decision compares two intervals. The first is the low-to-high interval from A to B. The second is the low-to-high interval from C to D, which is obtained as the A-to-D time minus the A-to-C time. Once the choice is made, the block issues a single transmit request carrying the response byte the host is waiting for:

- 0x86, echoed back, for UART mode;
- 0x30, queued as an acknowledge to be clocked out by the host, for synchronous mode.

If the fourth edge never arrives, the block gives up, flags an error and waits for a fresh first edge.

Top module: `link_mode_probe`

## Requirements
- R1: While reset is held and right after it is released, modeValid, txReq and errPulse are 0 and bitPeriod is 0.
- R2: Edges are taken in the fixed role order fall (A), rise (B), fall (C), rise (D). All intervals are measured in clock cycles of the sampled line. With tCD = tAD - tAC, modeSync is 1 (synchronous) when tAB > tCD, and 0 (UART) otherwise.
- R3: When tAB equals tCD exactly, UART mode (modeSync = 0) is chosen.
- R4: bitPeriod equals tAD shifted right by three bits, that is, tAD divided by 8 with the fraction dropped. It stays constant while modeValid is 1.
- R5: When UART mode is chosen, txReq is high for exactly one cycle with txByte = 0x86. That cycle is the first cycle in which modeValid is 1.
- R6: When synchronous mode is chosen, the single txReq cycle carries txByte = 0x30, whatever byte shape produced the decision.
- R7: Once modeValid is 1 it stays 1 until reset. Further line activity changes neither modeSync nor bitPeriod and raises no further txReq.
- R8: If the tick counter reaches 2^CNT_W - 1 after edge A and before edge D has been taken, errPulse is high for one cycle and modeValid stays 0. The block then returns to waiting for a new edge A, and a later byte is measured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Asynchronous serial receive line, idle high |
| modeValid | output | 1 | Decision made; stays set until reset |
| modeSync | output | 1 | 0 = UART, 1 = clocked synchronous |
| bitPeriod | output | CNT_W | tAD >> 3 in clock cycles |
| txReq | output | 1 | One-cycle request to send txByte |
| txByte | output | 8 | Response byte (0x86 or 0x30) |
| errPulse | output | 1 | One-cycle pulse on timeout or saturation |

## Verification
The bench builds the probe with CNT_W = 10 and leaves the synchronizer at two stages. With that counter width the saturation timeout falls about a thousand cycles after edge A, so both abandon paths can be driven within a short run: the line stuck low after A, and a byte whose fourth edge never comes. The vector table drives edge intervals directly in clock cycles. This reaches the tie between tAB and tCD, intervals of one cycle, and a span of 650 cycles, all well inside the 10-bit range.

// File: rtl/lmp_pkg.sv
package lmp_pkg;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic startA;
    logic capB;
    logic capC;
    logic capD;
    logic decide;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT_B = 3'd1,
    ST_WAIT_C = 3'd2,
    ST_WAIT_D = 3'd3,
    ST_DECIDE = 3'd4,
    ST_DONE   = 3'd5
  } probeState_t;

endpackage

// File: rtl/lmp_datapath.sv
module lmp_datapath
  import lmp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_SHIFT   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  dpStrobe_t        strb,
  output logic             fallEdge,
  output logic             riseEdge,
  output logic             cntSat,
  output logic             syncPick,
  output logic             modeSync,
  output logic [CNT_W-1:0] bitPeriod
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // synchronizer chain, reset to idle-high
  logic [SYNC_STAGES-1:0] syncQ;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= rxLine;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b1;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  logic lineS;
  logic linePrev;
  assign lineS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) linePrev <= 1'b1;
    else       linePrev <= lineS;
  end

  assign fallEdge = linePrev & ~lineS;
  assign riseEdge = ~linePrev & lineS;

  // saturating tick counter; reads k exactly k cycles after startA
  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (!rstN)            tickCnt <= '0;
    else if (strb.startA) tickCnt <= CNT_ONE;
    else if (!cntSat)     tickCnt <= tickCnt + CNT_ONE;
  end

  assign cntSat = (tickCnt == CNT_MAX);

  // edge timestamps relative to A
  logic [CNT_W-1:0] stampB;
  logic [CNT_W-1:0] stampC;
  logic [CNT_W-1:0] stampD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stampB <= '0;
      stampC <= '0;
      stampD <= '0;
    end else begin
      if (strb.capB) stampB <= tickCnt;
      if (strb.capC) stampC <= tickCnt;
      if (strb.capD) stampD <= tickCnt;
    end
  end

  logic [CNT_W-1:0] spanCD;
  assign spanCD   = stampD - stampC;
  assign syncPick = (stampB > spanCD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSync  <= 1'b0;
      bitPeriod <= '0;
    end else if (strb.decide) begin
      modeSync  <= syncPick;
      bitPeriod <= stampD >> DIV_SHIFT;
    end
  end

  // R2
  stamp_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.decide |-> (stampB < stampC) && (stampC < stampD));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.startA, strb.capB, strb.capC, strb.capD, strb.decide}));

  // R4
  period_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.decide |=> $stable(bitPeriod));

endmodule

// File: rtl/lmp_ctrl.sv
module lmp_ctrl
  import lmp_pkg::*;
#(
  parameter logic [7:0] UART_ACK = 8'h86,
  parameter logic [7:0] SYNC_ACK = 8'h30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fallEdge,
  input  logic       riseEdge,
  input  logic       cntSat,
  input  logic       syncPick,
  input  logic       modeSync,
  output dpStrobe_t  strb,
  output logic       modeValid,
  output logic       txReq,
  output logic [7:0] txByte,
  output logic       errPulse
);

  probeState_t state;
  probeState_t nxtState;
  logic        timeout;

  always_comb begin
    nxtState = state;
    strb     = '0;
    timeout  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (fallEdge) begin
          strb.startA = 1'b1;
          nxtState    = ST_WAIT_B;
        end
      end
      ST_WAIT_B: begin
        if (cntSat) begin
          timeout  = 1'b1;
          nxtState = ST_IDLE;
        end else if (riseEdge) begin
          strb.capB = 1'b1;
          nxtState  = ST_WAIT_C;
        end
      end
      ST_WAIT_C: begin
        if (cntSat) begin
          timeout  = 1'b1;
          nxtState = ST_IDLE;
        end else if (fallEdge) begin
          strb.capC = 1'b1;
          nxtState  = ST_WAIT_D;
        end
      end
      ST_WAIT_D: begin
        if (cntSat) begin
          timeout  = 1'b1;
          nxtState = ST_IDLE;
        end else if (riseEdge) begin
          strb.capD = 1'b1;
          nxtState  = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        strb.decide = 1'b1;
        nxtState    = ST_DONE;
      end
      ST_DONE:  nxtState = ST_DONE;
      default:  nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      txReq    <= 1'b0;
      txByte   <= 8'h00;
      errPulse <= 1'b0;
    end else begin
      state    <= nxtState;
      txReq    <= (state == ST_DECIDE);
      errPulse <= timeout;
      if (state == ST_DECIDE) txByte <= syncPick ? SYNC_ACK : UART_ACK;
    end
  end

  assign modeValid = (state == ST_DONE);

  // R5
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> !txReq);

  // R5
  req_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> $rose(modeValid));

  // R6
  req_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> (txByte == (modeSync ? SYNC_ACK : UART_ACK)));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeValid |=> modeValid);

  // R8
  err_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !modeValid && !txReq);

endmodule

// File: rtl/link_mode_probe.sv
module link_mode_probe
  import lmp_pkg::*;
#(
  parameter int         CNT_W       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         DIV_SHIFT   = 3,
  parameter logic [7:0] UART_ACK    = 8'h86,
  parameter logic [7:0] SYNC_ACK    = 8'h30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  output logic             modeValid,
  output logic             modeSync,
  output logic [CNT_W-1:0] bitPeriod,
  output logic             txReq,
  output logic [7:0]       txByte,
  output logic             errPulse
);

  dpStrobe_t strb;
  logic      fallEdge;
  logic      riseEdge;
  logic      cntSat;
  logic      syncPick;

  lmp_datapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .DIV_SHIFT  (DIV_SHIFT)
  ) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .strb     (strb),
    .fallEdge (fallEdge),
    .riseEdge (riseEdge),
    .cntSat   (cntSat),
    .syncPick (syncPick),
    .modeSync (modeSync),
    .bitPeriod(bitPeriod)
  );

  lmp_ctrl #(
    .UART_ACK(UART_ACK),
    .SYNC_ACK(SYNC_ACK)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .fallEdge (fallEdge),
    .riseEdge (riseEdge),
    .cntSat   (cntSat),
    .syncPick (syncPick),
    .modeSync (modeSync),
    .strb     (strb),
    .modeValid(modeValid),
    .txReq    (txReq),
    .txByte   (txByte),
    .errPulse (errPulse)
  );

endmodule

// File: tb/link_mode_probe_tb_top.sv
module link_mode_probe_tb_top;

  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rstN;
  logic             rxLine;
  logic             modeValid;
  logic             modeSync;
  logic [CNT_W-1:0] bitPeriod;
  logic             txReq;
  logic [7:0]       txByte;
  logic             errPulse;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  link_mode_probe #(.CNT_W(CNT_W)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .modeValid(modeValid),
    .modeSync (modeSync),
    .bitPeriod(bitPeriod),
    .txReq    (txReq),
    .txByte   (txByte),
    .errPulse (errPulse)
  );

  // per row: tAB, tBC, tCD, expected modeSync, expected bitPeriod
  localparam int NVEC = 7;
  localparam int VEC [NVEC][5] = '{
    '{16,  16,  32, 0,  8},   // 0x86 shape, 8 cycles per bit
    '{30,  12,  12, 1,  6},   // 0x30 shape, 6 cycles per bit
    '{10,   5,  10, 0,  3},   // tie -> UART
    '{11,   3,  10, 1,  3},   // tAB one above tCD
    '{ 1,   1,   1, 0,  0},   // one-cycle intervals
    '{ 3,   2,   1, 1,  0},
    '{200, 150, 300, 0, 81}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN   = 1'b0;
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendShape(input int ab, input int bc, input int cd);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (ab) @(negedge clk);
    rxLine = 1'b1;
    repeat (bc) @(negedge clk);
    rxLine = 1'b0;
    repeat (cd) @(negedge clk);
    rxLine = 1'b1;
  endtask

  // watch outputs for n cycles after a shape
  int  reqCount;
  int  reqByte;
  int  reqOffRise;
  int  errCount;
  bit  sawValid;

  task automatic collect(input int n);
    bit prevValid;
    prevValid  = modeValid;
    reqCount   = 0;
    reqByte    = -1;
    reqOffRise = 0;
    errCount   = 0;
    sawValid   = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (modeValid) sawValid = 1'b1;
      if (errPulse) errCount++;
      if (txReq) begin
        reqCount++;
        reqByte = txByte;
        if (!(modeValid && !prevValid)) reqOffRise++;
      end
      prevValid = modeValid;
    end
  endtask

  initial begin
    doReset();
    // R1
    check(!modeValid, "R1 modeValid", modeValid, 0);
    check(!txReq, "R1 txReq", txReq, 0);
    check(!errPulse, "R1 errPulse", errPulse, 0);
    check(bitPeriod == 0, "R1 bitPeriod", bitPeriod, 0);

    for (int v = 0; v < NVEC; v++) begin
      doReset();
      sendShape(VEC[v][0], VEC[v][1], VEC[v][2]);
      collect(20);
      check(sawValid, "R2 decision made", sawValid, 1);
      check(modeSync == VEC[v][3], (v == 2) ? "R3 tie mode" : "R2 mode", modeSync, VEC[v][3]);
      check(bitPeriod == VEC[v][4], "R4 period", bitPeriod, VEC[v][4]);
      check(reqCount == 1, "R5 one request", reqCount, 1);
      check(reqOffRise == 0, "R5 request on valid rise", reqOffRise, 0);
      if (VEC[v][3] == 1)
        check(reqByte == 8'h30, "R6 sync ack", reqByte, 8'h30);
      else
        check(reqByte == 8'h86, "R5 uart echo", reqByte, 8'h86);
    end

    // R7: result held against a later byte that would flip mode
    doReset();
    sendShape(16, 16, 32);
    collect(20);
    sendShape(30, 12, 12);
    collect(20);
    check(modeValid, "R7 valid held", modeValid, 1);
    check(modeSync == 0, "R7 mode held", modeSync, 0);
    check(bitPeriod == 8, "R7 period held", bitPeriod, 8);
    check(reqCount == 0, "R7 no new request", reqCount, 0);

    // R8: line stuck low after A
    doReset();
    @(negedge clk);
    rxLine = 1'b0;
    begin
      int firstErr;
      firstErr = -1;
      errCount = 0;
      sawValid = 1'b0;
      for (int i = 1; i <= 1200; i++) begin
        @(negedge clk);
        if (errPulse) begin
          errCount++;
          if (firstErr < 0) firstErr = i;
        end
        if (modeValid) sawValid = 1'b1;
      end
      check(errCount == 1, "R8 single error pulse", errCount, 1);
      check(firstErr >= 1015 && firstErr <= 1040, "R8 timeout time", firstErr, 1027);
      check(!sawValid, "R8 no decision", sawValid, 0);
    end
    rxLine = 1'b1;
    repeat (5) @(negedge clk);
    sendShape(30, 12, 12);
    collect(20);
    check(sawValid && modeSync == 1, "R8 recovery mode", modeSync, 1);
    check(bitPeriod == 6, "R8 recovery period", bitPeriod, 6);

    // R8: edge D never arrives
    doReset();
    @(negedge clk);
    rxLine = 1'b0;
    repeat (5) @(negedge clk);
    rxLine = 1'b1;
    repeat (5) @(negedge clk);
    rxLine = 1'b0;
    collect(1100);
    check(errCount == 1, "R8 missing D error", errCount, 1);
    check(!sawValid, "R8 missing D no decision", sawValid, 0);
    check(reqCount == 0, "R8 missing D no request", reqCount, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule